// File: doc/BRIEF.md
# Vector-Triggered Transfer Sequencer with Descriptor Cache

This block moves one data word each time an activation request arrives. Each request carries a vector number. A full activation reads a descriptor pointer from a vector table at `VEC_BASE + vector`. It then reads a three-word descriptor: source address, destination address, and a control word holding the count and the chain flag. It copies one word from the source to the destination and writes the updated descriptor back to memory. All memory traffic uses one single-port master with separate read and write strobes and a ready handshake.

The sequencer keeps the last vector number and that vector's descriptor in a one-entry cache. The same source can fire again while skipping is enabled and the cached entry is still valid. In that case the vector-table read and the three descriptor reads are left out, and the activation starts directly with the data read. Four conditions leave no valid entry for the next activation, so that activation does the full reload:

- the previous descriptor had its chain flag set;
- the previous activation brought the count to zero;
- skipping was disabled;
- the per-source enable was withdrawn.

Top module: `xfer_skip_ctrl`

## Requirements
- R1: A full activation makes exactly these accesses, in this order:
  - a read at `VEC_BASE + vector`;
  - reads at P, P+1 and P+2, where P is the low `AW` bits of the vector word;
  - a read at the source address;
  - a write of that data to the destination;
  - write-back writes at P, P+1 and P+2.
- R2: When `skip_en` is 1, the cache is valid and the request's vector equals the cached vector, the activation begins with the data read. No vector or descriptor reads are made. The data read, data write and three write-backs follow, using the cached pointer and descriptor.
- R3: A request whose vector differs from the cached one performs a full activation, and its vector then replaces the cached one.
- R4: If the descriptor of the previous activation had the chain flag (control word bit `DW-1`) set, the next activation performs a full reload even with a matching vector.
- R5: If the previous activation left the count (control word bits `CW-1:0`) at zero after decrementing, the next activation performs a full reload even with a matching vector.
- R6: Driving `skip_en` to 0 invalidates the cache, and with `skip_en` at 0 every activation is full. After `skip_en` returns to 1, the next activation reads the vector table and descriptor afresh and uses the updated memory contents.
- R7: While `src_en` is 0, requests are ignored: there are no accesses and no `done` pulse, and the cache is invalidated. The first activation after `src_en` returns to 1 is full.
- R8: The write-back words are:
  - source + 1;
  - destination + 1;
  - the control word with the count decremented by one and the chain flag kept (all other bits zero).
- R9: Each access holds its strobe, address and write data until `mem_ready` is sampled high. `mem_rd` and `mem_wr` are never high together.
- R10: `done` is high for exactly one cycle after the last write-back completes. A request that arrives while an activation is in progress is ignored.
- R11: After reset, both strobes and `done` are low and the cache is empty, so the first activation is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Activation request, sampled while idle |
| req_vec | input | VW | Vector number of the request |
| src_en | input | 1 | Per-source enable; 0 ignores requests and invalidates the cache |
| skip_en | input | 1 | Descriptor-read skip enable; 0 invalidates the cache |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Access completes in a cycle where this is high |
| done | output | 1 | One-cycle pulse at the end of an activation |

## Verification
The hardest state to reach from the ports is a cache that holds a matching vector but must still be ignored. This covers a descriptor whose chain flag was set, a count that has just reached zero, and an entry that was invalidated after memory was edited behind it. The stimulus builds each case with a first activation that leaves the cache in that exact state, then fires the same vector again. The scoreboard expects either the full reload or the short sequence. In the invalidation case, the descriptor in memory is changed while skipping is off, so a stale cached copy would show up as wrong write-back addresses. Random wait states on `mem_ready` run in the later half, together with a request that arrives mid-activation.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_VEC,
    PH_DESC,
    PH_DRD,
    PH_DWR,
    PH_WB,
    PH_DONE
  } phase_e;

  localparam int unsigned DESC_WORDS = 3;
  localparam int unsigned BEAT_W     = 2;

endpackage

// File: rtl/xfer_tag_cache.sv
module xfer_tag_cache #(
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          skip_en,
  input  logic          src_en,
  input  logic          fill,
  input  logic          fill_ok,
  input  logic [VW-1:0] fill_vec,
  input  logic [VW-1:0] probe_vec,
  output logic          valid,
  output logic          match
);

  logic [VW-1:0] tag_q;

  // Invalidation has priority over a fill in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag_q <= '0;
    end else if (!skip_en || !src_en) begin
      valid <= 1'b0;
    end else if (fill) begin
      valid <= fill_ok;
      tag_q <= fill_vec;
    end
  end

  // The comparison runs regardless of skip_en.
  assign match = valid && (tag_q == probe_vec);

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xfer_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 32,
  parameter int unsigned   VW       = 8,
  parameter int unsigned   CW       = 16,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [VW-1:0] req_vec,
  input  logic          src_en,
  input  logic          hit,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          start_o,
  output logic          skip_o,
  output logic          fill_o,
  output logic          fill_ok_o,
  output logic [VW-1:0] cur_vec_o,
  output logic          busy_o,
  output logic          done_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(DESC_WORDS - 1);

  phase_e            st;
  logic [BEAT_W-1:0] beat;
  logic [VW-1:0]     cur_vec;
  logic [AW-1:0]     dptr, src, dst;
  logic [CW-1:0]     cnt;
  logic              chain;
  logic [DW-1:0]     dbuf;

  function automatic logic [AW-1:0] vec_addr(input logic [VW-1:0] v);
    return VEC_BASE + AW'(v);
  endfunction

  function automatic logic [DW-1:0] pack_ctl(input logic ch, input logic [CW-1:0] c);
    logic [DW-1:0] w;
    w         = '0;
    w[CW-1:0] = c;
    w[DW-1]   = ch;
    return w;
  endfunction

  function automatic logic [DW-1:0] wb_word(input logic [BEAT_W-1:0] b);
    case (b)
      2'd0:    return DW'(src);
      2'd1:    return DW'(dst);
      default: return pack_ctl(chain, cnt);
    endcase
  endfunction

  always_comb begin
    mem_rd    = (st == PH_VEC) || (st == PH_DESC) || (st == PH_DRD);
    mem_wr    = (st == PH_DWR) || (st == PH_WB);
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      PH_VEC:         mem_addr = vec_addr(cur_vec);
      PH_DESC, PH_WB: mem_addr = dptr + AW'(beat);
      PH_DRD:         mem_addr = src;
      PH_DWR:         mem_addr = dst;
      default:        mem_addr = '0;
    endcase
    if (st == PH_DWR) mem_wdata = dbuf;
    if (st == PH_WB)  mem_wdata = wb_word(beat);
  end

  assign start_o   = (st == PH_IDLE) && req && src_en;
  assign skip_o    = start_o && hit;
  assign fill_o    = (st == PH_WB) && (beat == LAST_BEAT) && mem_ready;
  assign fill_ok_o = !chain && (cnt != '0);
  assign cur_vec_o = cur_vec;
  assign busy_o    = (st != PH_IDLE);
  assign done_o    = (st == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      beat    <= '0;
      cur_vec <= '0;
      dptr    <= '0;
      src     <= '0;
      dst     <= '0;
      cnt     <= '0;
      chain   <= 1'b0;
      dbuf    <= '0;
    end else begin
      case (st)
        PH_IDLE: if (start_o) begin
          cur_vec <= req_vec;
          st      <= hit ? PH_DRD : PH_VEC;
        end
        PH_VEC: if (mem_ready) begin
          dptr <= mem_rdata[AW-1:0];
          beat <= '0;
          st   <= PH_DESC;
        end
        PH_DESC: if (mem_ready) begin
          case (beat)
            2'd0:    src <= mem_rdata[AW-1:0];
            2'd1:    dst <= mem_rdata[AW-1:0];
            default: begin
              cnt   <= mem_rdata[CW-1:0];
              chain <= mem_rdata[DW-1];
            end
          endcase
          if (beat == LAST_BEAT) begin
            beat <= '0;
            st   <= PH_DRD;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        PH_DRD: if (mem_ready) begin
          dbuf <= mem_rdata;
          st   <= PH_DWR;
        end
        PH_DWR: if (mem_ready) begin
          src  <= src + 1'b1;
          dst  <= dst + 1'b1;
          cnt  <= cnt - 1'b1;
          beat <= '0;
          st   <= PH_WB;
        end
        PH_WB: if (mem_ready) begin
          if (beat == LAST_BEAT) st <= PH_DONE;
          else                   beat <= beat + 1'b1;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xfer_skip_ctrl.sv
module xfer_skip_ctrl #(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 32,
  parameter int unsigned   VW       = 8,
  parameter int unsigned   CW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [VW-1:0] req_vec,
  input  logic          src_en,
  input  logic          skip_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          done
);

  logic          start_w, skip_w, fill_w, fill_ok_w, busy_w;
  logic          cache_valid_w, match_w, hit_w;
  logic [VW-1:0] cur_vec_w;

  assign hit_w = skip_en && match_w;

  xfer_tag_cache #(.VW(VW)) cache_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .skip_en   (skip_en),
    .src_en    (src_en),
    .fill      (fill_w),
    .fill_ok   (fill_ok_w),
    .fill_vec  (cur_vec_w),
    .probe_vec (req_vec),
    .valid     (cache_valid_w),
    .match     (match_w)
  );

  xfer_sequencer #(
    .AW(AW), .DW(DW), .VW(VW), .CW(CW), .VEC_BASE(VEC_BASE)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_vec   (req_vec),
    .src_en    (src_en),
    .hit       (hit_w),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .start_o   (start_w),
    .skip_o    (skip_w),
    .fill_o    (fill_w),
    .fill_ok_o (fill_ok_w),
    .cur_vec_o (cur_vec_w),
    .busy_o    (busy_w),
    .done_o    (done)
  );

endmodule

// File: rtl/xfer_skip_ctrl_chk.sv
module xfer_skip_ctrl_chk #(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 32,
  parameter int unsigned   VW       = 8,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] req_vec,
  input logic          src_en,
  input logic          skip_en,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          done,
  input logic          start_w,
  input logic          skip_w,
  input logic          busy_w,
  input logic          cache_valid_w
);

  assert_full_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && !skip_w) |=> (mem_rd && mem_addr == VEC_BASE + AW'($past(req_vec))));

  assert_skip_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skip_w |=> (mem_rd && !mem_wr));

  assert_inval_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_en |=> !cache_valid_w);

  assert_inval_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> !cache_valid_w);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_hold_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  assert_hold_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy_w));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (!mem_rd && !mem_wr && !done));

endmodule

bind xfer_skip_ctrl xfer_skip_ctrl_chk #(
  .AW(AW), .DW(DW), .VW(VW), .VEC_BASE(VEC_BASE)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_vec       (req_vec),
  .src_en        (src_en),
  .skip_en       (skip_en),
  .mem_addr      (mem_addr),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .mem_wdata     (mem_wdata),
  .mem_ready     (mem_ready),
  .done          (done),
  .start_w       (start_w),
  .skip_w        (skip_w),
  .busy_w        (busy_w),
  .cache_valid_w (cache_valid_w)
);

// File: tb/xfer_skip_ctrl_tb_top.sv
module xfer_skip_ctrl_tb_top;
  localparam int unsigned   AW = 16;
  localparam int unsigned   DW = 32;
  localparam int unsigned   VW = 8;
  localparam int unsigned   CW = 16;
  localparam logic [AW-1:0] VB = 16'h0040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [VW-1:0] req_vec = '0;
  logic          src_en = 1'b1;
  logic          skip_en = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_ready = 1'b1;
  logic          done;

  always #4 clk = ~clk;

  xfer_skip_ctrl #(.AW(AW), .DW(DW), .VW(VW), .CW(CW), .VEC_BASE(VB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_vec(req_vec), .src_en(src_en),
    .skip_en(skip_en), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done)
  );

  // Behavioural memory: 1024 words, the low address bits index it.
  logic [DW-1:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_wr && mem_ready) mem[mem_addr[9:0]] <= mem_wdata;

  logic       wait_mode = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= wait_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int acc_cnt  = 0;
  int wait_cnt = 0;
  logic prev_done = 1'b0;
  logic finished  = 1'b0;

  typedef struct {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } acc_t;
  acc_t expq[$];

  task automatic chk(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic push(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
    acc_t e;
    e.wr = wr; e.addr = a; e.data = d; e.tag = tag;
    expq.push_back(e);
  endtask

  // Scoreboard monitor: compare each completed access with the queue head.
  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_rd || mem_wr) && !mem_ready) wait_cnt++;
      if ((mem_rd || mem_wr) && mem_ready) begin
        acc_cnt++;
        if (expq.size() == 0) begin
          chk(1'b0, "R1", $sformatf("unexpected access wr=%0b addr=%h actual vs expected none",
                                    mem_wr, mem_addr));
        end else begin
          acc_t e;
          e = expq.pop_front();
          chk(e.wr == mem_wr && e.addr == mem_addr && (!e.wr || e.data == mem_wdata), e.tag,
              $sformatf("access actual wr=%0b addr=%h data=%h expected wr=%0b addr=%h data=%h",
                        mem_wr, mem_addr, mem_wdata, e.wr, e.addr, e.data));
        end
      end
      if (done) begin
        done_cnt++;
        if (prev_done) chk(1'b0, "R10", "done actual 2 cycles expected 1");
      end
      prev_done <= done;
    end
  end

  function automatic logic [AW-1:0] rd_a(input logic [AW-1:0] a);
    return mem[a[9:0]][AW-1:0];
  endfunction

  // Expected access list, computed from the bench's memory.
  task automatic expect_act(input logic [VW-1:0] v, input bit full, input string tag);
    logic [AW-1:0] dp, s, d;
    logic [DW-1:0] ctl, nctl;
    dp = rd_a(VB + AW'(v));
    if (full) begin
      push(1'b0, VB + AW'(v), '0, tag);
      push(1'b0, dp, '0, tag);
      push(1'b0, dp + 1, '0, tag);
      push(1'b0, dp + 2, '0, tag);
    end
    s   = rd_a(dp);
    d   = rd_a(dp + 1);
    ctl = mem[(dp + 16'd2) & 16'h03FF];
    push(1'b0, s, '0, tag);
    push(1'b1, d, mem[s[9:0]], tag);
    nctl          = '0;
    nctl[DW-1]    = ctl[DW-1];
    nctl[CW-1:0]  = ctl[CW-1:0] - 1'b1;
    push(1'b1, dp,     DW'(s + 1'b1), "R8");
    push(1'b1, dp + 1, DW'(d + 1'b1), "R8");
    push(1'b1, dp + 2, nctl,          "R8");
  endtask

  task automatic pulse_req(input logic [VW-1:0] v);
    @(negedge clk);
    req = 1'b1; req_vec = v;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(input int start_cnt, input string tag);
    for (int i = 0; i < 400 && done_cnt == start_cnt; i++) @(negedge clk);
    @(negedge clk);
    chk(done_cnt == start_cnt + 1, tag,
        $sformatf("done pulses actual %0d expected %0d", done_cnt - start_cnt, 1));
    chk(expq.size() == 0, tag,
        $sformatf("missing accesses actual %0d left expected 0", expq.size()));
  endtask

  task automatic fire(input logic [VW-1:0] v, input bit full, input string tag);
    int c;
    c = done_cnt;
    expect_act(v, full, tag);
    pulse_req(v);
    wait_done(c, tag);
  endtask

  task automatic setup(input logic [VW-1:0] v, input logic [AW-1:0] dp, input logic [AW-1:0] s,
                       input logic [AW-1:0] d, input logic [CW-1:0] c, input logic ch);
    logic [DW-1:0] w;
    w = '0; w[CW-1:0] = c; w[DW-1] = ch;
    mem[(VB + AW'(v)) & 16'h03FF] = DW'(dp);
    mem[dp[9:0]]                  = DW'(s);
    mem[(dp + 16'd1) & 16'h03FF]  = DW'(d);
    mem[(dp + 16'd2) & 16'h03FF]  = w;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + i;
    setup(8'd3,  16'h0100, 16'h0200, 16'h0300, 16'd5, 1'b0);
    setup(8'd7,  16'h0110, 16'h0220, 16'h0320, 16'd6, 1'b0);
    setup(8'd9,  16'h0120, 16'h0240, 16'h0340, 16'd8, 1'b1);
    setup(8'd12, 16'h0130, 16'h0260, 16'h0360, 16'd2, 1'b0);

    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr && !done, "R11",
        $sformatf("reset outputs actual rd=%0b wr=%0b done=%0b expected 0 0 0", mem_rd, mem_wr, done));
    rst_n = 1'b1;
    skip_en = 1'b1;
    @(negedge clk);

    fire(8'd3, 1'b1, "R11");  // first after reset: full
    fire(8'd3, 1'b0, "R2");   // same source: skip
    fire(8'd3, 1'b0, "R2");
    fire(8'd7, 1'b1, "R3");   // different source
    fire(8'd3, 1'b1, "R3");   // tag was replaced
    fire(8'd3, 1'b0, "R2");

    wait_mode = 1'b1;
    fire(8'd9, 1'b1, "R1");   // chain flag set
    fire(8'd9, 1'b1, "R4");
    fire(8'd9, 1'b1, "R4");
    chk(wait_cnt > 0, "R9", $sformatf("wait cycles actual %0d expected >0", wait_cnt));

    fire(8'd12, 1'b1, "R1");  // count 2 -> 1
    fire(8'd12, 1'b0, "R2");  // count 1 -> 0
    fire(8'd12, 1'b1, "R5");  // zero count forces reload
    fire(8'd12, 1'b0, "R5");  // count wrapped to nonzero: skip again

    // R6: invalidate via skip_en, edit descriptor behind the cache.
    fire(8'd3, 1'b1, "R3");
    @(negedge clk); skip_en = 1'b0;
    fire(8'd3, 1'b1, "R6");
    mem[16'h0101] = 32'h0000_0380;
    @(negedge clk); skip_en = 1'b1;
    fire(8'd3, 1'b1, "R6");
    fire(8'd3, 1'b0, "R6");

    // R7: requests ignored while src_en is low, cache invalidated.
    begin
      int c0, a0;
      @(negedge clk); src_en = 1'b0;
      c0 = done_cnt; a0 = acc_cnt;
      pulse_req(8'd3);
      repeat (20) @(negedge clk);
      chk(done_cnt == c0, "R7", $sformatf("done actual %0d expected %0d", done_cnt, c0));
      chk(acc_cnt == a0, "R7", $sformatf("accesses actual %0d expected %0d", acc_cnt, a0));
      src_en = 1'b1;
      fire(8'd3, 1'b1, "R7");
    end

    // R10: a second request while busy is ignored.
    begin
      int c1;
      c1 = done_cnt;
      expect_act(8'd7, 1'b1, "R10");
      pulse_req(8'd7);
      repeat (2) @(negedge clk);
      pulse_req(8'd3);
      wait_done(c1, "R10");
      repeat (20) @(negedge clk);
      chk(done_cnt == c1 + 1, "R10", $sformatf("done actual %0d expected %0d", done_cnt, c1 + 1));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule